// File: doc/BRIEF.md
# Key-Sequenced Digital Watchdog

This block is a digital watchdog timer. Software keeps it alive by writing two keys in a fixed order to a 16-bit key field that sits in the low half of a 32-bit register. The first key arms the block and the second key services it. A service reloads a down counter. The counter's upper bits come from a preload input and its lower bits are set to all ones. If the counter runs down to zero while enabled, or if software writes any value that is not one of the two keys, the block raises a reset request. That request stays high until the next system reset.

A privileged key write passes through a fixed-length pipeline before the key logic sees it, so a service needs a few cycles to take effect. The counter loads its start value when the enable first goes high and then counts down by one on each clock. The counter's width is the preload width plus a parameterised number of low bits that fill with ones on a load. The pipeline length and both key values are also parameters.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rst_req` is 0 and `count` is 0.
- R2: A privileged write of the arming key (0xE51A) followed by a separate privileged write of the servicing key (0xA35C) reloads `count` with `{preload, all ones in the low LOW_W bits}`. The `preload` used is the value present at the reload edge.
- R3: A servicing-key write while the block is not armed changes neither `count` nor `rst_req`.
- R4: Several arming-key writes in a row keep the block armed, and the next servicing key still reloads the counter.
- R5: After a service the block is unarmed, so a second servicing key with no arming key in between has no effect.
- R6: A privileged key write whose low 16 bits are neither 0xE51A nor 0xA35C sets `rst_req`.
- R7: A key write sampled at clock edge E acts at edge E+LAT. Before that edge, `count` and `rst_req` behave as if no write had happened.
- R8: A write with `wr_priv` low or with `wr_sel` low is ignored. It does not arm, does not service and does not raise a reset, even when its value is invalid.
- R9: At the first edge where `wd_enable` is high after being low, `count` loads `{preload, ones}`. While the enable stays high, `count` falls by one per clock. While the enable is low, `count` holds.
- R10: When `wd_enable` has been high for more than one cycle and `count` is 0 with no service at that edge, `rst_req` is set. Once set, `rst_req` stays high until reset.
- R11: Bits 31:16 of `wr_data` are reserved and do not affect key decoding. `rd_data` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Selects the key register for this write |
| wr_priv | input | 1 | Write is made in privileged mode |
| wr_data | input | DATA_W | Write data; key in the low KEY_W bits |
| rd_data | output | DATA_W | Read data of the key register, always zero |
| preload | input | PRE_W | Upper-bit reload value for the counter |
| wd_enable | input | 1 | Counter enable |
| count | output | PRE_W+LOW_W | Current down-counter value |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block with PRE_W=4, LOW_W=5 and LAT=3, so the counter is 9 bits wide and a full load is at most 511. Expiry and the sticky reset request are therefore reached within a few hundred cycles, including the shortest load of 31 when the preload is zero. With the three-stage pipeline, a service can overlap with later key writes and with counter expiry. The bench keeps the 16-bit key width, so both real key values and invalid values with nonzero reserved bits are used.

// File: rtl/wdt_pkg.sv
// Shared types for the key-sequenced watchdog.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package wdt_pkg;

    // Classification of one key value leaving the write pipeline
    typedef enum logic [1:0] {
        KEV_NONE = 2'd0,
        KEV_ARM  = 2'd1,
        KEV_SVC  = 2'd2,
        KEV_BAD  = 2'd3
    } key_ev_t;

endpackage

// File: rtl/wdt_key_pipe.sv
// Fixed-latency delay line for accepted key writes.
// Does: carries a valid flag and key value through LAT register stages.
// Assumes: LAT >= 1; only filtered (selected, privileged) writes enter.
module wdt_key_pipe #(
    parameter int DW  = 16,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_key,
    output logic          out_vld,
    output logic [DW-1:0] out_key
);
    logic          vld_q [LAT];
    logic [DW-1:0] key_q [LAT];

    // First stage captures the incoming write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            key_q[0] <= '0;
        end else begin
            vld_q[0] <= in_vld;
            key_q[0] <= in_key;
        end
    end

    genvar g;
    generate
        for (g = 1; g < LAT; g++) begin : g_stage
            // Each further stage shifts the previous stage forward
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    key_q[g] <= '0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    key_q[g] <= key_q[g-1];
                end
            end
        end
    endgenerate

    assign out_vld = vld_q[LAT-1];
    assign out_key = key_q[LAT-1];
endmodule

// File: rtl/wdt_key_seq.sv
// Arming/servicing key sequencer.
// Does: classifies each delayed key; the arming key sets the armed flag,
//       the servicing key gives a one-cycle service pulse when armed and
//       clears the flag, and any other value gives a one-cycle bad pulse.
// Assumes: the key arrives already delayed and privilege-filtered.
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int          KW      = 16,
    parameter logic [KW-1:0] ARM_KEY = 16'hE51A,
    parameter logic [KW-1:0] SVC_KEY = 16'hA35C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_vld,
    input  logic [KW-1:0] key,
    output logic          armed,
    output logic          svc_hit,
    output logic          bad_hit
);
    key_ev_t ev;

    // Decode the key value into an event
    always_comb begin
        if (!key_vld)            ev = KEV_NONE;
        else if (key == ARM_KEY) ev = KEV_ARM;
        else if (key == SVC_KEY) ev = KEV_SVC;
        else                     ev = KEV_BAD;
    end

    assign svc_hit = (ev == KEV_SVC) && armed;
    assign bad_hit = (ev == KEV_BAD);

    // Track the armed state across writes
    always_ff @(posedge clk) begin
        if (!rst_n)               armed <= 1'b0;
        else if (ev == KEV_ARM)   armed <= 1'b1;
        else if (svc_hit)         armed <= 1'b0;
    end
endmodule

// File: rtl/wdt_down_counter.sv
// Watchdog down counter.
// Does: loads {preload, ones} when first enabled or on service, counts
//       down while enabled, holds while disabled, flags expiry at zero.
// Assumes: service and enable may coincide; both load the same value.
module wdt_down_counter #(
    parameter int PRE_W = 12,
    parameter int LOW_W = 13,
    localparam int CW   = PRE_W + LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] preload,
    input  logic             reload,
    output logic [CW-1:0]    cnt,
    output logic             en_q,
    output logic             expired
);
    logic [CW-1:0] load_val;
    logic          start;

    assign load_val = {preload, {LOW_W{1'b1}}};
    assign start    = enable && !en_q;
    assign expired  = enable && en_q && (cnt == '0) && !reload;

    // Remember last cycle's enable to find the first enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Update the count: load, decrement or hold
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (start || reload)        cnt <= load_val;
        else if (enable && cnt != '0)    cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/keyed_watchdog.sv
// Key-sequenced digital watchdog, top level.
// Does: filters register writes by select and privilege, delays them,
//       runs the key sequence, drives the counter and a sticky reset request.
// Assumes: DATA_W > KEY_W; the key sits in the low KEY_W bits of a write.
module keyed_watchdog #(
    parameter int              DATA_W  = 32,
    parameter int              KEY_W   = 16,
    parameter int              PRE_W   = 12,
    parameter int              LOW_W   = 13,
    parameter int              LAT     = 3,
    parameter logic [KEY_W-1:0] ARM_KEY = 16'hE51A,
    parameter logic [KEY_W-1:0] SVC_KEY = 16'hA35C,
    localparam int             CW      = PRE_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic              wr_priv,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PRE_W-1:0]  preload,
    input  logic              wd_enable,
    output logic [CW-1:0]     count,
    output logic              rst_req
);
    logic             acc_wr;
    logic             dly_vld;
    logic [KEY_W-1:0] dly_key;
    logic             armed;
    logic             svc_hit;
    logic             bad_hit;
    logic             en_q;
    logic             expired;
    logic             unused_rsvd;

    assign acc_wr      = wr_en && wr_sel && wr_priv;
    assign unused_rsvd = ^wr_data[DATA_W-1:KEY_W];
    assign rd_data     = '0;

    wdt_key_pipe #(.DW(KEY_W), .LAT(LAT)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (acc_wr),
        .in_key  (wr_data[KEY_W-1:0]),
        .out_vld (dly_vld),
        .out_key (dly_key)
    );

    wdt_key_seq #(.KW(KEY_W), .ARM_KEY(ARM_KEY), .SVC_KEY(SVC_KEY)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_vld (dly_vld),
        .key     (dly_key),
        .armed   (armed),
        .svc_hit (svc_hit),
        .bad_hit (bad_hit)
    );

    wdt_down_counter #(.PRE_W(PRE_W), .LOW_W(LOW_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (wd_enable),
        .preload (preload),
        .reload  (svc_hit),
        .cnt     (count),
        .en_q    (en_q),
        .expired (expired)
    );

    // Latch a reset request on a bad key or on expiry until system reset
    always_ff @(posedge clk) begin
        if (!rst_n)                    rst_req <= 1'b0;
        else if (bad_hit || expired)   rst_req <= 1'b1;
    end
endmodule

// File: rtl/wdt_checker.sv
// Property checker for keyed_watchdog, attached by bind.
// Does: checks stickiness, reload value, sequencing and counting.
// Assumes: observed signals are sampled on the rising clock edge.
module wdt_checker #(
    parameter int PRE_W = 12,
    parameter int LOW_W = 13,
    localparam int CW   = PRE_W + LOW_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic [CW-1:0]    count,
    input logic [PRE_W-1:0] preload,
    input logic             wd_enable,
    input logic             en_q,
    input logic             svc_hit,
    input logic             bad_hit,
    input logic             armed
);
    // R10: request is sticky
    p_req_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R6: bad key raises the request
    p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_hit |=> rst_req);

    // R2: service loads preload and ones
    p_service_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hit |=> count == {$past(preload), {LOW_W{1'b1}}});

    // R5: service leaves the block unarmed
    p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hit |=> !armed);

    // R9: running counter falls by one
    p_decrement_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_enable && en_q && !svc_hit && count != '0) |=> count == $past(count) - 1'b1);

    // R9: disabled counter holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_enable && !svc_hit) |=> $stable(count));
endmodule

bind keyed_watchdog wdt_checker #(.PRE_W(PRE_W), .LOW_W(LOW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .count     (count),
    .preload   (preload),
    .wd_enable (wd_enable),
    .en_q      (en_q),
    .svc_hit   (svc_hit),
    .bad_hit   (bad_hit),
    .armed     (armed)
);

// File: tb/keyed_watchdog_bench.sv
// Bench for keyed_watchdog: a cycle model built from the requirements,
// directed corner cases, then seeded random key traffic.
module keyed_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W = 4;
    localparam int LOW_W = 5;
    localparam int LAT   = 3;
    localparam int CW    = PRE_W + LOW_W;
    localparam logic [15:0] K_ARM = 16'hE51A;
    localparam logic [15:0] K_SVC = 16'hA35C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sel = 1'b0, wr_priv = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [PRE_W-1:0] preload = '0;
    logic          wd_enable = 1'b0;
    logic [CW-1:0] count;
    logic          rst_req;

    int checks = 0, failures = 0, cyc = 0;
    string cur_req = "R1";

    // reference model state
    logic          m_vld [LAT];
    logic [15:0]   m_key [LAT];
    logic          m_armed, m_en_q, m_req;
    logic [CW-1:0] m_cnt;

    keyed_watchdog #(.PRE_W(PRE_W), .LOW_W(LOW_W), .LAT(LAT)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_priv(wr_priv),
        .wr_data(wr_data), .rd_data(rd_data), .preload(preload),
        .wd_enable(wd_enable), .count(count), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [CW-1:0] load_of(input logic [PRE_W-1:0] p);
        return {p, {LOW_W{1'b1}}};
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // advance the model by one clock edge with the inputs now driven
    task automatic model_step();
        logic svc, bad, exp_now;
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin m_vld[i] = 0; m_key[i] = 0; end
            m_armed = 0; m_en_q = 0; m_req = 0; m_cnt = '0;
            return;
        end
        svc = 0; bad = 0;
        if (m_vld[LAT-1]) begin
            if (m_key[LAT-1] == K_ARM) m_armed = 1;
            else if (m_key[LAT-1] == K_SVC) begin
                if (m_armed) begin svc = 1; m_armed = 0; end
            end else bad = 1;
        end
        exp_now = wd_enable && m_en_q && m_cnt == 0 && !svc;
        if ((wd_enable && !m_en_q) || svc) m_cnt = load_of(preload);
        else if (wd_enable && m_cnt != 0) m_cnt = m_cnt - 1'b1;
        if (bad || exp_now) m_req = 1;
        m_en_q = wd_enable;
        for (int i = LAT-1; i > 0; i--) begin m_vld[i] = m_vld[i-1]; m_key[i] = m_key[i-1]; end
        m_vld[0] = wr_en && wr_sel && wr_priv;
        m_key[0] = wr_data[15:0];
    endtask

    // one clock: inputs already set; model, edge, then compare mid-cycle
    task automatic tick();
        model_step();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        check({cur_req, " count"}, count, m_cnt);
        check({cur_req, " rst_req"}, rst_req, m_req);
        wr_en = 0; wr_sel = 0; wr_priv = 0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [31:0] d, input logic sel, input logic priv);
        wr_en = 1; wr_sel = sel; wr_priv = priv; wr_data = d;
        tick();
    endtask

    task automatic do_reset();
        rst_n = 0; wd_enable = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        do_reset();
        check("R1 count", count, 0);
        check("R1 rst_req", rst_req, 0);
        check("R11 rd_data", rd_data, 0);

        // R9: first enable loads, then counts down
        cur_req = "R9";
        preload = 4'd5; wd_enable = 1;
        tick();
        check("R9 load on enable", count, load_of(4'd5));
        idle(4);
        check("R9 decrement", count, load_of(4'd5) - 4);

        // R3: service key while unarmed
        cur_req = "R3";
        wr({16'h0, K_SVC}, 1, 1); idle(LAT + 2);

        // R4 and R7: repeated arming, then service with exact latency
        cur_req = "R4";
        wr({16'h0, K_ARM}, 1, 1); wr({16'h0, K_ARM}, 1, 1); wr({16'h0, K_ARM}, 1, 1);
        idle(LAT);
        cur_req = "R7";
        preload = 4'd9;
        wr({16'h0, K_SVC}, 1, 1);
        idle(LAT - 1);
        check("R7 before effect", count != load_of(4'd9), 1);
        tick();
        check("R7 reload at latency", count, load_of(4'd9));
        check("R2 reload value", count, load_of(4'd9));

        // R5: second service key ignored
        cur_req = "R5";
        idle(3);
        wr({16'h0, K_SVC}, 1, 1); idle(LAT + 1);
        check("R5 no second reload", count, load_of(4'd9) - (LAT + 5));

        // R8: unprivileged or unselected writes ignored
        cur_req = "R8";
        wr({16'h0, K_ARM}, 1, 0); wr({16'h0, K_SVC}, 1, 1); idle(LAT + 1);
        wr(32'h0000_1234, 1, 0); wr(32'h0000_1234, 0, 1); idle(LAT + 1);
        check("R8 no reset", rst_req, 0);

        // R11: reserved bits ignored, read is zero
        cur_req = "R11";
        wr({16'hFFFF, K_ARM}, 1, 1); wr({16'h5A5A, K_SVC}, 1, 1); idle(LAT + 1);
        check("R11 rd_data", rd_data, 0);

        // R9: hold while disabled
        cur_req = "R9";
        wd_enable = 0; idle(5); wd_enable = 1; idle(2);

        // R6: invalid key raises sticky request
        cur_req = "R6";
        wr(32'h0000_2345, 1, 1); idle(LAT);
        check("R6 bad key", rst_req, 1);
        idle(5);
        check("R10 sticky", rst_req, 1);

        // R10: expiry with shortest load
        cur_req = "R10";
        do_reset();
        preload = 0; wd_enable = 1;
        idle(LOAD_WAIT());
        check("R10 expired", rst_req, 1);

        // random traffic, with periodic reset
        cur_req = "R2";
        void'($urandom(32'd20250711));
        do_reset();
        wd_enable = 1;
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 2) preload = PRE_W'($urandom);
            if (r == 3) wd_enable = ~wd_enable;
            if (r < 25) begin
                wr_en = 1; wr_sel = ($urandom_range(0, 9) != 0); wr_priv = ($urandom_range(0, 9) != 0);
                case ($urandom_range(0, 19))
                    0:       wr_data = $urandom;
                    1, 2, 3, 4, 5, 6, 7, 8, 9: wr_data = {16'($urandom), K_ARM};
                    default: wr_data = {16'($urandom), K_SVC};
                endcase
            end
            if (rst_req && $urandom_range(0, 19) == 0) begin
                do_reset(); wd_enable = 1;
            end else tick();
        end
        finish_run();
    end

    function automatic int LOAD_WAIT();
        return (1 << LOW_W) + 2;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // watchdog on the bench itself
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end
endmodule